// File: doc/BRIEF.md
# Memory Device Test Access Port Controller

This block is the serial test port of a synchronous memory device. It runs the sixteen-state test access port state machine from a test clock and a mode-select input, keeps a three-bit instruction, and puts one of three data paths between the serial input and the serial output: a one-bit pass-through stage, a 32-bit identification word, or a boundary register of parameter length that captures the values on the device pads. Two of the instructions also raise a control that turns the memory's functional data outputs off (high impedance) for as long as that instruction is the current one.

The controller has no separate test reset pin. A power-on reset puts it in its reset state. Holding the mode-select input high for five test clock rising edges returns it there from any state. In both cases the identification instruction becomes the current one. Mode select and serial input are taken on the rising edge of the test clock. The serial output and its enable change only on the falling edge.

Top module: `sram_test_port`

## Requirements
- R1: After power-on reset, the serial output enable and the output-disable control are low, and the first data scan returns the identification word, so the identification instruction is current.
- R2: From any state, five rising edges with mode select high put the controller in its reset state. At the next rising edge the identification instruction becomes current again and the output-disable control drops.
- R3: Mode select and serial input are sampled on the rising test clock edge. The serial output holds its value across the rising edge and takes the next bit only at the falling edge.
- R4: The serial output enable is high exactly while the controller is in Shift-IR or Shift-DR, timed by the falling edge. It is low in every other state, including Pause-DR.
- R5: Capture-IR loads the binary pattern 001 into the instruction shift stage. It is shifted out least significant bit first, so a three-bit IR scan returns 1, 0, 0.
- R6: A shifted opcode becomes the current instruction only on the rising edge that leaves Update-IR. Until then the output-disable control keeps the value set by the previous instruction.
- R7: Opcode 001 selects the identification register. Capture-DR loads the word with revision in bits 31:28 (parameter), part number 0x003C in bits 27:12, vendor code 0x010 in bits 11:1 and a constant 1 in bit 0. Shifting starts with bit 0.
- R8: Opcodes 011, 101, 110 and 111 select the one-bit pass-through stage. It captures 0, and each input bit reaches the output one shift later.
- R9: Opcode 100 selects the boundary register with the output-disable control low. Capture-DR loads `padValues`, and pad bit 0 (boundary position 1) is the first bit shifted out.
- R10: Opcode 000 behaves like opcode 100 on the boundary register, but the output-disable control is high while it is current.
- R11: Opcode 010 selects the boundary register, captures the pads in the same way, and holds the output-disable control high while current.
- R12: Pause-DR and the Exit2-DR return to Shift-DR keep the selected data register intact, so a scan split by a pause returns the same bit stream as an uninterrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data input, sampled on the rising edge |
| porRstN | input | 1 | Active-low asynchronous power-on reset |
| padValues | input | BSR_LEN | Pad values loaded into the boundary register at capture |
| tdo | output | 1 | Serial data output, updated on the falling edge |
| tdoOe | output | 1 | Enable for the serial output driver |
| forceHiZ | output | 1 | Turns the functional data outputs off while high |

## Verification
The assertions assume the power-on reset is low from time zero until a few clock edges have passed. They also assume mode select and serial input are always driven, since an undriven input must look like logic 1 and a board pull-up has to supply that. The stimulus changes both inputs only two nanoseconds after each falling edge and samples the outputs at that same moment. Every rising edge therefore sees settled inputs, and every sample sees the output of the latest falling edge. Pad values change only while the controller is in Run-Test/Idle, so no capture ever meets a changing pad.

// File: rtl/sram_test_port_pkg.sv
package sram_test_port_pkg;

  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    PATH_SKIP,
    PATH_IDENT,
    PATH_PADS
  } drPath_e;

  // Opcode map; the three spare codes (101, 110, 111) fall back to the skip path.
  localparam logic [IR_W-1:0] OP_PADS_QUIET = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT      = 3'b001;
  localparam logic [IR_W-1:0] OP_PADS_HIZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SKIP       = 3'b011;
  localparam logic [IR_W-1:0] OP_PADS_LIVE  = 3'b100;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 3'b001;

  typedef struct packed {
    logic    captureDr;
    logic    shiftDr;
    logic    shiftIr;
    drPath_e path;
  } drStrobe_t;

endpackage

// File: rtl/stp_ctrl.sv
module stp_ctrl
  import sram_test_port_pkg::*;
(
  input  logic      tck,
  input  logic      porRstN,
  input  logic      tms,
  input  logic      tdi,
  output tapState_e state,
  output drStrobe_t strobe,
  output logic      irSerial,
  output logic      forceHiZ
);

  tapState_e stateNext;
  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] instr;

  // Sixteen-state walk, one branch per mode-select value
  always_comb begin
    stateNext = state;
    unique case (state)
      TAP_RESET: stateNext = tms ? TAP_RESET : TAP_IDLE;
      TAP_IDLE:  stateNext = tms ? SEL_DR    : TAP_IDLE;
      SEL_DR:    stateNext = tms ? SEL_IR    : CAP_DR;
      CAP_DR:    stateNext = tms ? EX1_DR    : SHF_DR;
      SHF_DR:    stateNext = tms ? EX1_DR    : SHF_DR;
      EX1_DR:    stateNext = tms ? UPD_DR    : PAU_DR;
      PAU_DR:    stateNext = tms ? EX2_DR    : PAU_DR;
      EX2_DR:    stateNext = tms ? UPD_DR    : SHF_DR;
      UPD_DR:    stateNext = tms ? SEL_DR    : TAP_IDLE;
      SEL_IR:    stateNext = tms ? TAP_RESET : CAP_IR;
      CAP_IR:    stateNext = tms ? EX1_IR    : SHF_IR;
      SHF_IR:    stateNext = tms ? EX1_IR    : SHF_IR;
      EX1_IR:    stateNext = tms ? UPD_IR    : PAU_IR;
      PAU_IR:    stateNext = tms ? EX2_IR    : PAU_IR;
      EX2_IR:    stateNext = tms ? UPD_IR    : SHF_IR;
      UPD_IR:    stateNext = tms ? SEL_DR    : TAP_IDLE;
      default:   stateNext = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN) state <= TAP_RESET;
    else          state <= stateNext;
  end

  // Instruction shift stage: fixed pattern at capture, LSB leaves first
  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)               irShift <= IR_CAPTURE_PAT;
    else if (state == CAP_IR)   irShift <= IR_CAPTURE_PAT;
    else if (state == SHF_IR)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // Current instruction: identification on reset, new opcode only from Update-IR
  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)                instr <= OP_IDENT;
    else if (state == TAP_RESET) instr <= OP_IDENT;
    else if (state == UPD_IR)    instr <= irShift;
  end

  drPath_e pathSel;
  always_comb begin
    unique case (instr)
      OP_IDENT:                               pathSel = PATH_IDENT;
      OP_PADS_QUIET, OP_PADS_HIZ, OP_PADS_LIVE: pathSel = PATH_PADS;
      default:                                pathSel = PATH_SKIP;
    endcase
  end

  assign strobe.captureDr = (state == CAP_DR);
  assign strobe.shiftDr   = (state == SHF_DR);
  assign strobe.shiftIr   = (state == SHF_IR);
  assign strobe.path      = pathSel;
  assign irSerial         = irShift[0];
  assign forceHiZ         = (instr == OP_PADS_QUIET) || (instr == OP_PADS_HIZ);

  // R2: five consecutive high mode-select samples land in the reset state
  p_five_ones_reset_r2: assert property (@(posedge tck) disable iff (!porRstN)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == TAP_RESET));

  // R5: leaving Capture-IR always leaves the fixed pattern in the shift stage
  p_ir_capture_r5: assert property (@(posedge tck) disable iff (!porRstN)
    (state == CAP_IR) |=> (irShift == IR_CAPTURE_PAT));

  // R6: the current instruction moves only out of Update-IR or the reset state
  p_instr_update_only_r6: assert property (@(posedge tck) disable iff (!porRstN)
    !$stable(instr) |-> ($past(state) == UPD_IR || $past(state) == TAP_RESET));

endmodule

// File: rtl/stp_datapath.sv
module stp_datapath
  import sram_test_port_pkg::*;
#(
  parameter int          BSR_LEN = 70,
  parameter logic [31:0] ID_WORD = 32'h0003_C021
) (
  input  logic               tck,
  input  logic               porRstN,
  input  logic               tdi,
  input  drStrobe_t          strobe,
  input  logic               irSerial,
  input  logic [BSR_LEN-1:0] padValues,
  output logic               tdo,
  output logic               tdoOe
);

  localparam int ID_W = 32;

  logic               skipQ;
  logic [ID_W-1:0]    identQ;
  logic [BSR_LEN-1:0] bsrQ;

  logic skipCap, skipShift, identCap, identShift, bsrCap, bsrShift;
  assign skipCap    = strobe.captureDr && (strobe.path == PATH_SKIP);
  assign skipShift  = strobe.shiftDr   && (strobe.path == PATH_SKIP);
  assign identCap   = strobe.captureDr && (strobe.path == PATH_IDENT);
  assign identShift = strobe.shiftDr   && (strobe.path == PATH_IDENT);
  assign bsrCap     = strobe.captureDr && (strobe.path == PATH_PADS);
  assign bsrShift   = strobe.shiftDr   && (strobe.path == PATH_PADS);

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)       skipQ <= 1'b0;
    else if (skipCap)   skipQ <= 1'b0;
    else if (skipShift) skipQ <= tdi;
  end

  always_ff @(posedge tck or negedge porRstN) begin
    if (!porRstN)        identQ <= '0;
    else if (identCap)   identQ <= ID_WORD;
    else if (identShift) identQ <= {tdi, identQ[ID_W-1:1]};
  end

  // Boundary chain: cell 0 sits next to the serial output
  for (genvar gi = 0; gi < BSR_LEN; gi++) begin : g_cell
    logic shiftSrc;
    logic cellQ;
    if (gi == BSR_LEN - 1) begin : g_head
      assign shiftSrc = tdi;
    end else begin : g_body
      assign shiftSrc = bsrQ[gi+1];
    end
    always_ff @(posedge tck or negedge porRstN) begin
      if (!porRstN)      cellQ <= 1'b0;
      else if (bsrCap)   cellQ <= padValues[gi];
      else if (bsrShift) cellQ <= shiftSrc;
    end
    assign bsrQ[gi] = cellQ;
  end

  logic drSerial;
  always_comb begin
    unique case (strobe.path)
      PATH_IDENT: drSerial = identQ[0];
      PATH_PADS:  drSerial = bsrQ[0];
      default:    drSerial = skipQ;
    endcase
  end

  // Output stage retimed to the falling edge
  always_ff @(negedge tck or negedge porRstN) begin
    if (!porRstN) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdo   <= strobe.shiftIr ? irSerial : drSerial;
      tdoOe <= strobe.shiftIr || strobe.shiftDr;
    end
  end

  // R7: the identification register holds the full word after its capture
  p_id_capture_r7: assert property (@(posedge tck) disable iff (!porRstN)
    identCap |=> (identQ == ID_WORD));

  // R8: the skip stage always captures zero
  p_skip_capture_r8: assert property (@(posedge tck) disable iff (!porRstN)
    skipCap |=> (skipQ == 1'b0));

  // R9: boundary capture copies the pads seen at the capture edge
  p_pad_capture_r9: assert property (@(posedge tck) disable iff (!porRstN)
    bsrCap |=> (bsrQ == $past(padValues)));

endmodule

// File: rtl/sram_test_port.sv
module sram_test_port
  import sram_test_port_pkg::*;
#(
  parameter int           BSR_LEN     = 70,
  parameter logic [3:0]   ID_REVISION = 4'h0,
  parameter logic [15:0]  ID_PART     = 16'h003C,
  parameter logic [10:0]  ID_VENDOR   = 11'h010
) (
  input  logic               tck,
  input  logic               tms,
  input  logic               tdi,
  input  logic               porRstN,
  input  logic [BSR_LEN-1:0] padValues,
  output logic               tdo,
  output logic               tdoOe,
  output logic               forceHiZ
);

  localparam logic [31:0] ID_WORD = {ID_REVISION, ID_PART, ID_VENDOR, 1'b1};

  tapState_e ctrlState;
  drStrobe_t strobe;
  logic      irSerial;

  stp_ctrl u_ctrl (
    .tck      (tck),
    .porRstN  (porRstN),
    .tms      (tms),
    .tdi      (tdi),
    .state    (ctrlState),
    .strobe   (strobe),
    .irSerial (irSerial),
    .forceHiZ (forceHiZ)
  );

  stp_datapath #(
    .BSR_LEN (BSR_LEN),
    .ID_WORD (ID_WORD)
  ) u_datapath (
    .tck       (tck),
    .porRstN   (porRstN),
    .tdi       (tdi),
    .strobe    (strobe),
    .irSerial  (irSerial),
    .padValues (padValues),
    .tdo       (tdo),
    .tdoOe     (tdoOe)
  );

  // R4: driver enable seen at a rising edge matches the shift state entered one edge before
  p_tdo_enable_r4: assert property (@(posedge tck) disable iff (!porRstN)
    tdoOe == (ctrlState == SHF_DR || ctrlState == SHF_IR));

endmodule

// File: tb/sram_test_port_tb.sv
`timescale 1ns/1ps
module sram_test_port_tb;

  localparam int         BSR = 10;
  localparam logic [3:0] REV = 4'hA;
  localparam logic [31:0] ID_EXP = {REV, 16'h003C, 11'b00000010000, 1'b1};
  localparam int         SCAN_N = 40;

  logic tck = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic porRstN = 1'b0;
  logic [BSR-1:0] padValues = '0;
  logic tdo, tdoOe, forceHiZ;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 tck = ~tck;

  sram_test_port #(.BSR_LEN(BSR), .ID_REVISION(REV)) u_dut (
    .tck(tck), .tms(tms), .tdi(tdi), .porRstN(porRstN), .padValues(padValues),
    .tdo(tdo), .tdoOe(tdoOe), .forceHiZ(forceHiZ)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One rising edge per call; inputs set and outputs read 2 ns after the falling edge
  task automatic step(input logic tmsV, input logic tdiV, output logic tdoV, output logic enV);
    @(negedge tck); #2;
    tms = tmsV; tdi = tdiV; tdoV = tdo; enV = tdoOe;
  endtask

  task automatic loadIr(input logic [2:0] op, output logic [2:0] irOut, output logic enShift,
                        output logic hizBefore, output logic hizAfter, output logic enIdle);
    logic o, e;
    enShift = 1'b1;
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int k = 0; k < 3; k++) begin
      step(logic'(k == 2), op[k], o, e);
      irOut[k] = o; enShift &= e;
    end
    step(1, 0, o, e);
    step(0, 0, o, e); hizBefore = forceHiZ;
    step(0, 0, o, e); hizAfter = forceHiZ; enIdle = e;
  endtask

  task automatic scanDr(input int n, input logic [63:0] inBits, output logic [63:0] outBits, output logic enAll);
    logic o, e;
    outBits = '0; enAll = 1'b1;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int k = 0; k < n; k++) begin
      step(logic'(k == n - 1), inBits[k], o, e);
      outBits[k] = o; enAll &= e;
    end
    step(1, 0, o, e); step(0, 0, o, e);
  endtask

  function automatic logic [63:0] expScan(input int n, input int len, input logic [63:0] cap, input logic [63:0] inB);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k] = (k < len) ? cap[k] : inB[k - len];
    return r;
  endfunction

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'b000: return "R10";
      3'b001: return "R7";
      3'b010: return "R11";
      3'b100: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic o, e, hb, ha, en, enIdle;
    logic [2:0] irOut;
    logic [63:0] outB, inB, cap;
    logic prevHiz;
    int len;

    repeat (3) @(posedge tck);
    #3 porRstN = 1'b1;

    // R1: reset state
    step(1, 1, o, e);
    check("R1", "tdoOe after reset", e, 0);
    check("R1", "forceHiZ after reset", forceHiZ, 0);
    step(0, 0, o, e);
    check("R1", "tdoOe in idle", e, 0);
    scanDr(32, 64'h0, outB, en);
    check("R1", "default instruction gives ID word", outB[31:0], ID_EXP);
    check("R4", "enable through shift", en, 1);

    // Sweep all eight opcodes, two scans each with fresh pads and data
    prevHiz = 1'b0;
    for (int op = 0; op < 8; op++) begin
      logic expHiz;
      expHiz = (op == 0) || (op == 2);
      loadIr(3'(op), irOut, en, hb, ha, enIdle);
      check("R5", "IR capture pattern", irOut, 3'b001);
      check("R4", "enable in Shift-IR", en, 1);
      check("R4", "enable low in idle", enIdle, 0);
      check("R6", "hiz before update", hb, prevHiz);
      check(opTag(3'(op)), "hiz after update", ha, expHiz);
      prevHiz = expHiz;
      for (int rep = 0; rep < 2; rep++) begin
        padValues = BSR'(10'h2A5 ^ (op * 37) ^ (rep * 10'h3C3));
        inB = 64'hC3A5_96F0_1E7B_5D2C ^ (64'(op) << (rep * 8 + 3));
        case (op)
          1: begin len = 32; cap = 64'(ID_EXP); end
          0, 2, 4: begin len = BSR; cap = 64'(padValues); end
          default: begin len = 1; cap = 64'h0; end
        endcase
        scanDr(SCAN_N, inB, outB, en);
        check(opTag(3'(op)), "data scan stream", outB & ((64'h1 << SCAN_N) - 1),
              expScan(SCAN_N, len, cap, inB));
        check("R4", "enable in Shift-DR", en, 1);
      end
    end

    // R3: output holds across the rising edge, moves at the falling edge (skip path)
    loadIr(3'b011, irOut, en, hb, ha, enIdle);
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    @(negedge tck); #2; tms = 0; tdi = 1;
    check("R3", "tdo before rising edge", tdo, 0);
    @(posedge tck); #2;
    check("R3", "tdo just after rising edge", tdo, 0);
    @(negedge tck); #2;
    check("R3", "tdo after falling edge", tdo, 1);
    step(1, 0, o, e); step(1, 0, o, e); step(0, 0, o, e);

    // R12: identification scan split by a pause
    loadIr(3'b001, irOut, en, hb, ha, enIdle);
    outB = '0;
    step(1, 0, o, e); step(0, 0, o, e); step(0, 0, o, e);
    for (int k = 0; k < 12; k++) begin
      step(logic'(k == 11), 0, o, e); outB[k] = o;
    end
    step(0, 0, o, e);
    step(0, 0, o, e);
    step(1, 0, o, e);
    check("R4", "enable low in Pause-DR", e, 0);
    step(0, 0, o, e);
    for (int k = 12; k < 32; k++) begin
      step(logic'(k == 31), 0, o, e); outB[k] = o;
    end
    step(1, 0, o, e); step(0, 0, o, e);
    check("R12", "paused scan stream", outB[31:0], ID_EXP);

    // R2: five high mode-select edges from many states restore the ID instruction
    for (int p = 0; p <= 12; p++) begin
      logic [12:0] path;
      path = 13'b0_1001_0110_0010;
      loadIr(3'b010, irOut, en, hb, ha, enIdle);
      for (int k = 0; k < p; k++) step(path[k], 0, o, e);
      for (int k = 0; k < 5; k++) step(1, 0, o, e);
      step(0, 0, o, e);
      step(0, 0, o, e);
      check("R2", "hiz dropped after reset walk", forceHiZ, 0);
      scanDr(32, 64'h0, outB, en);
      check("R2", "ID selected after reset walk", outB[31:0], ID_EXP);
    end

    finishRun();
  end

endmodule